// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-bit register, widened through a parameter, that on each rising clock edge does one of five things: clears itself, shifts toward the high end, shifts toward the low end, loads a parallel word, or holds. A two-bit select picks the operation. An active-low synchronous clear takes priority over the select. The parallel data lines are shared between input and output. They are modelled as three parts: a captured-data input vector, a contents output vector, and one drive-enable that tells the surrounding pad logic when to drive the lines.

The drive-enable is true only when both active-low output enables are low and the select is not in load mode. An external source can therefore put a word on the lines for a load without any contention. The lowest and highest bits also appear on two dedicated serial taps, and these stay valid whatever the output enables are doing. Two or more instances can be chained into a longer shifter: one tap feeds the neighbour's serial input in each direction.

The operation decoder resolves the inputs into one enumerated mode per cycle: CLEAR (clear low), LOAD (select 11), SHR (select 01), SHL (select 10) and HOLD (select 00). The register moves from its current contents to the value that mode defines on every edge. There is no other sequencing.

Top module: `ushift_reg`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, all bits become 0 after that edge, whatever `sel`, the enables, the serial inputs and `pin_in` are.
- R2: With `clr_n`=1 and `sel`=2'b11 (load), bit n takes `pin_in[n]` at the edge.
- R3: With `clr_n`=1 and `sel`=2'b01 (shift toward the high end), bit 0 takes `ser_up_in` and bit n takes the old bit n-1.
- R4: With `clr_n`=1 and `sel`=2'b10 (shift toward the low end), the top bit takes `ser_dn_in` and bit n takes the old bit n+1.
- R5: With `clr_n`=1 and `sel`=2'b00, the contents do not change.
- R6: `pin_drive` is 0 whenever `oen_a` or `oen_b` is 1.
- R7: `pin_drive` is 0 whenever `sel`=2'b11, and it is 1 when both enables are 0 and `sel` is not 2'b11.
- R8: `pin_out` always equals the contents, `tap_lo` equals bit 0 and `tap_hi` equals the top bit, regardless of the enables.
- R9: Clear, load, shift and hold work the same while `pin_drive` is 0 because an enable is high.
- R10: `pin_in` has no effect on the contents in any mode other than load.
- R11: Two instances chained through their taps and serial inputs behave as one 16-bit register in both shift directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all changes on rising edge |
| clr_n | input | 1 | Synchronous clear, active low, overrides sel |
| sel | input | 2 | Mode select: 00 hold, 01 shift up, 10 shift down, 11 load |
| ser_up_in | input | 1 | Serial bit entering bit 0 on shift up |
| ser_dn_in | input | 1 | Serial bit entering the top bit on shift down |
| oen_a | input | 1 | Output enable A, active low |
| oen_b | input | 1 | Output enable B, active low |
| pin_in | input | WIDTH | Value seen on the shared lines, captured in load mode |
| pin_out | output | WIDTH | Register contents presented to the shared lines |
| pin_drive | output | 1 | High when the shared lines are driven |
| tap_lo | output | 1 | Bit 0, always valid |
| tap_hi | output | 1 | Top bit, always valid |

## Verification
On every cycle the assertions check the next-state rule of each mode, the clear override, both conditions that turn the drive off, and that the taps follow the end bits. Some behaviour only the bench scenarios can show. These are: the full sweep of enable and select combinations against an arithmetic model, the fact that `pin_in` changes leave the contents alone outside load, and the carry of bits across the boundary when two instances are chained into a 16-bit shifter in both directions.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
    typedef enum logic [2:0] {
        OP_HOLD  = 3'd0,
        OP_SHR   = 3'd1,
        OP_SHL   = 3'd2,
        OP_LOAD  = 3'd3,
        OP_CLEAR = 3'd4
    } op_t;

    localparam logic [1:0] SEL_HOLD = 2'b00;
    localparam logic [1:0] SEL_SHR  = 2'b01;
    localparam logic [1:0] SEL_SHL  = 2'b10;
    localparam logic [1:0] SEL_LOAD = 2'b11;
endpackage

// File: rtl/ushift_decode.sv
module ushift_decode
    import ushift_pkg::*;
(
    input  logic       clr_n,
    input  logic [1:0] sel,
    output op_t        op
);
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else begin
            unique case (sel)
                SEL_HOLD: op = OP_HOLD;
                SEL_SHR:  op = OP_SHR;
                SEL_SHL:  op = OP_SHL;
                default:  op = OP_LOAD;
            endcase
        end
    end
endmodule

// File: rtl/ushift_next.sv
module ushift_next
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_t              op,
    input  logic [WIDTH-1:0] cur,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] nxt
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = pin_in;
            OP_SHR:   nxt = {cur[MSB-1:0], ser_up_in};
            OP_SHL:   nxt = {ser_dn_in, cur[MSB:1]};
            default:  nxt = cur;
        endcase
    end
endmodule

// File: rtl/ushift_drive.sv
module ushift_drive
    import ushift_pkg::*;
(
    input  logic       oen_a,
    input  logic       oen_b,
    input  logic [1:0] sel,
    output logic       pin_drive
);
    logic enabled;
    logic loading;

    always_comb begin
        enabled   = ~(oen_a | oen_b);
        loading   = (sel == SEL_LOAD);
        pin_drive = enabled & ~loading;
    end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       sel,
    input  logic             ser_up_in,
    input  logic             ser_dn_in,
    input  logic             oen_a,
    input  logic             oen_b,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic             pin_drive,
    output logic             tap_lo,
    output logic             tap_hi
);
    localparam int MSB = WIDTH - 1;

    op_t              op;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] nxt;

    ushift_decode dec_i (
        .clr_n (clr_n),
        .sel   (sel),
        .op    (op)
    );

    ushift_next #(.WIDTH(WIDTH)) nxt_i (
        .op        (op),
        .cur       (cur_q),
        .ser_up_in (ser_up_in),
        .ser_dn_in (ser_dn_in),
        .pin_in    (pin_in),
        .nxt       (nxt)
    );

    ushift_drive drv_i (
        .oen_a     (oen_a),
        .oen_b     (oen_b),
        .sel       (sel),
        .pin_drive (pin_drive)
    );

    // State register: contents advance once per rising edge.
    always_ff @(posedge clk) begin
        cur_q <= nxt;
    end

    // Output process: contents and end taps, independent of the enables.
    always_comb begin
        pin_out = cur_q;
        tap_lo  = cur_q[0];
        tap_hi  = cur_q[MSB];
    end
endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clr_n,
    input logic [1:0]       sel,
    input logic             ser_up_in,
    input logic             ser_dn_in,
    input logic             oen_a,
    input logic             oen_b,
    input logic [WIDTH-1:0] pin_in,
    input logic [WIDTH-1:0] pin_out,
    input logic             pin_drive,
    input logic             tap_lo,
    input logic             tap_hi
);
    localparam int MSB = WIDTH - 1;

    // The clear property is triggered by the clear itself.
    p_clear_r1: assert property (@(posedge clk)
        !clr_n |=> (pin_out == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |=> (pin_out == $past(pin_in)));

    p_shift_up_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b01) |=> (pin_out == {$past(pin_out[MSB-1:0]), $past(ser_up_in)}));

    p_shift_dn_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b10) |=> (pin_out == {$past(ser_dn_in), $past(pin_out[MSB:1])}));

    p_hold_r5: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b00) |=> $stable(pin_out));

    p_oe_off_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (oen_a || oen_b) |-> !pin_drive);

    p_load_off_r7: assert property (@(posedge clk) disable iff (!clr_n)
        (sel == 2'b11) |-> !pin_drive);

    p_taps_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (tap_lo == pin_out[0]) && (tap_hi == pin_out[MSB]));
endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) chk_i (
    .clk       (clk),
    .clr_n     (clr_n),
    .sel       (sel),
    .ser_up_in (ser_up_in),
    .ser_dn_in (ser_dn_in),
    .oen_a     (oen_a),
    .oen_b     (oen_b),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_drive (pin_drive),
    .tap_lo    (tap_lo),
    .tap_hi    (tap_hi)
);

// File: tb/ushift_reg_tb_top.sv
module ushift_reg_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n;
    logic [1:0]   sel;
    logic         up_in, dn_in, oa, ob;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_out;
    logic         pin_drive, tap_lo, tap_hi;

    // Cascade pair
    logic         c_clr_n;
    logic [1:0]   c_sel;
    logic         c_up, c_dn;
    logic [W-1:0] lo_out, hi_out;
    logic         lo_drv, hi_drv, lo_tl, lo_th, hi_tl, hi_th;

    int total = 0;
    int bad   = 0;
    logic [W-1:0]    model;
    logic [2*W-1:0]  cmodel;

    always #4 clk = ~clk;

    ushift_reg #(.WIDTH(W)) dut_i (
        .clk(clk), .clr_n(clr_n), .sel(sel), .ser_up_in(up_in), .ser_dn_in(dn_in),
        .oen_a(oa), .oen_b(ob), .pin_in(pin_in), .pin_out(pin_out),
        .pin_drive(pin_drive), .tap_lo(tap_lo), .tap_hi(tap_hi));

    ushift_reg #(.WIDTH(W)) lo_i (
        .clk(clk), .clr_n(c_clr_n), .sel(c_sel), .ser_up_in(c_up), .ser_dn_in(hi_tl),
        .oen_a(1'b0), .oen_b(1'b0), .pin_in('0), .pin_out(lo_out),
        .pin_drive(lo_drv), .tap_lo(lo_tl), .tap_hi(lo_th));

    ushift_reg #(.WIDTH(W)) hi_i (
        .clk(clk), .clr_n(c_clr_n), .sel(c_sel), .ser_up_in(lo_th), .ser_dn_in(c_dn),
        .oen_a(1'b0), .oen_b(1'b0), .pin_in('0), .pin_out(hi_out),
        .pin_drive(hi_drv), .tap_lo(hi_tl), .tap_hi(hi_th));

    task automatic chk(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive inputs at negedge, clock once, compare at the following negedge.
    task automatic step(input logic r, input logic [1:0] s, input logic u, input logic d,
                        input logic a, input logic b, input logic [W-1:0] p, input string req);
        clr_n = r; sel = s; up_in = u; dn_in = d; oa = a; ob = b; pin_in = p;
        #1;
        chk("R6/R7 drive", {15'd0, pin_drive}, {15'd0, (!a && !b && s != 2'b11)});
        @(posedge clk);
        if (!r)              model = '0;
        else if (s == 2'b11) model = p;
        else if (s == 2'b01) model = {model[W-2:0], u};
        else if (s == 2'b10) model = {d, model[W-1:1]};
        @(negedge clk);
        chk(req, {8'd0, pin_out}, {8'd0, model});
        chk("R8 taps", {14'd0, tap_hi, tap_lo}, {14'd0, model[W-1], model[0]});
    endtask

    task automatic cstep(input logic r, input logic [1:0] s, input logic u, input logic d);
        c_clr_n = r; c_sel = s; c_up = u; c_dn = d;
        @(posedge clk);
        if (!r)              cmodel = '0;
        else if (s == 2'b01) cmodel = {cmodel[2*W-2:0], u};
        else if (s == 2'b10) cmodel = {d, cmodel[2*W-1:1]};
        @(negedge clk);
        chk("R11 cascade", {hi_out, lo_out}, cmodel);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr_n = 0; sel = 0; up_in = 0; dn_in = 0; oa = 0; ob = 0; pin_in = '0;
        c_clr_n = 0; c_sel = 0; c_up = 0; c_dn = 0;
        model = '0; cmodel = '0;
        @(negedge clk);
        // R1 reset state
        step(0, 2'b11, 1, 1, 0, 0, 8'hFF, "R1 clear");

        // R1: clear overrides every select with nonzero contents
        for (int s = 0; s < 4; s++) begin
            step(1, 2'b11, 0, 0, 0, 0, 8'hA5 ^ 8'(s), "R2 load");
            step(0, 2'(s), 1, 1, s[0], s[1], 8'hFF, "R1 clear override");
        end

        // Full enable x select sweep, all modes, random data (R2-R7, R9, R10)
        for (int rep = 0; rep < 40; rep++) begin
            for (int c = 0; c < 16; c++) begin
                logic [W-1:0] p;
                p = 8'($urandom);
                step(1, 2'(c), 1'($urandom), 1'($urandom), c[2], c[3], p,
                     (c[1:0] == 2'b11) ? "R2 load R9" :
                     (c[1:0] == 2'b01) ? "R3 shift up R10" :
                     (c[1:0] == 2'b10) ? "R4 shift down R10" : "R5 hold R10");
            end
        end

        // R10: hold with pin_in toggling hard
        step(1, 2'b11, 0, 0, 1, 1, 8'h3C, "R2 load");
        for (int k = 0; k < 8; k++)
            step(1, 2'b00, 1, 1, 0, 0, ~8'(k * 37), "R10 hold ignores pin_in");

        // R3/R4 walking patterns: fill ones up then zeros down
        for (int k = 0; k < W; k++) step(1, 2'b01, 1, 0, 0, 1, 8'h00, "R3 walk");
        for (int k = 0; k < W; k++) step(1, 2'b10, 1, 0, 1, 0, 8'hFF, "R4 walk");

        // R11 cascade: clear, shift a pattern up across the boundary, then down
        cstep(0, 2'b00, 0, 0);
        for (int k = 0; k < 20; k++) cstep(1, 2'b01, 1'(k % 3 == 0), 0);
        for (int k = 0; k < 20; k++) cstep(1, 2'b10, 0, 1'(k % 2));
        cstep(1, 2'b00, 1, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule